// File: doc/BRIEF.md
# Output-Stage Serial Slave with Frame Checksum

This block is the serial front end of an eight-channel switched-output controller. A host drives chip select, a serial clock and a data line. Each transfer updates the eight drive bits, or reads or writes a small register space, while the block returns the channel diagnosis byte, supply status flags and a checksum on the return line. Two strap inputs pick one of four frame layouts: an 8-bit plain drive frame, a 16-bit drive frame protected by a 5-bit checksum, a 16-bit register access frame, and a 24-bit register access frame protected by a checksum.

The serial inputs are brought into the system clock domain through a synchronizer, and clock edges are detected there. A three-state machine controls each transfer. `ST_IDLE` waits with chip select high and tracks the strap inputs. A chip-select fall moves it to `ST_SHIFT`, which shifts bits in on clock rises and out on clock falls. A chip-select rise moves it to `ST_COMMIT`, which checks the bit count and the checksum in one cycle, applies or drops the frame, and always returns to `ST_IDLE`. A frame that fails either check changes no register and raises the error flag. The flag stays up until a frame passes both checks.

Top module: `outstage_spi_slave`

## Requirements
- R1: `sdo_oe` is low whenever `cs_n` is high and high whenever `cs_n` is low; `sdo_oe` is the enable an external pad uses to drive `sdo`.
- R2: SDI is captured on rising SCLK and SDO moves on falling SCLK. Both directions send the most significant bit first. The first return bit is valid before the first rising edge of the frame.
- R3: With `mode_sel`=0 the frame is 8 bits long. The SDI byte becomes the drive value, and SDO returns the 8-bit diagnosis snapshot taken at chip-select fall.
- R4: With `mode_sel`=1 the frame is 16 bits long. SDI carries the drive byte, three zero bits and a 5-bit checksum. SDO returns the diagnosis byte, then the status bits in the order uv, mv, cf, then a 5-bit checksum.
- R5: With `mode_sel`=2 the frame is 16 bits long. First-byte bit 7 is the direction, where 1 means write and 0 means read, and bits 6..0 are the address. A write to address 0x00 loads the drive value with the second byte, and writes to other addresses change nothing. A read returns, in the second SDO byte, the drive value for address 0x00, the diagnosis snapshot for address 0x01, and zero for any other address. A write returns zero in that byte. The first SDO byte is the diagnosis snapshot.
- R6: With `mode_sel`=3 the frame is 24 bits long. SDI carries the direction/address byte, a data byte that is zero on reads, three zero bits and a checksum. SDO returns the diagnosis byte, then the read data (zero on writes), then uv, mv, cf, then a checksum.
- R7: The checksum uses the generator x^5+x^2+1 and starts from 11111. It is computed MSB first over every bit that comes before the checksum field in the same direction: 11 bits in mode 1 and 19 bits in mode 3.
- R8: A frame whose bit count at chip-select rise differs from its mode's length is dropped and sets `crc_err`.
- R9: In modes 1 and 3, a received checksum that does not match is dropped and sets `crc_err`. `crc_err` clears when the next frame passes all its checks. Modes 0 and 2 carry no checksum.
- R10: `mode_sel` is taken only while chip select is high. A change during a frame does not alter that frame's decoding.
- R11: After reset, `drive` is 0x00 and `crc_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from host |
| mode_sel | input | 2 | Frame layout strap, 0..3 |
| diag_in | input | 8 | Per-channel diagnosis byte |
| uv | input | 1 | Supply undervoltage status |
| mv | input | 1 | Supply missing status |
| cf | input | 1 | Transfer fault status |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for the sdo pad |
| drive | output | 8 | Channel drive value |
| crc_err | output | 1 | Frame rejected flag |

## Verification
A table of frames covers all four layouts with varied diagnosis and status patterns. It separates the modes by where status and checksum bits land, and it separates read from write by what the second return byte holds. Register reads at the drive address, the diagnosis address and an unused address show that address decode selects the right source. Corrupted-checksum frames, frames one bit short and frames one bit long each leave the drive value untouched and raise the flag. A clean frame placed after each of them shows the flag clears. A strap change in the middle of a frame shows that the layout is locked at chip-select fall.

// File: rtl/outstage_spi_pkg.sv
package outstage_spi_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 5;
    localparam int STAT_W = 3;
    localparam int CNT_W  = 5;
    localparam int SHIFT_W = 24;

    localparam logic [CRC_W-1:0] CRC_POLY = 5'h05;
    localparam logic [CRC_W-1:0] CRC_SEED = 5'h1f;

    typedef enum logic [1:0] {
        FMT_DRV8   = 2'd0,
        FMT_DRV16C = 2'd1,
        FMT_REG16  = 2'd2,
        FMT_REG24C = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } st_e;

    function automatic logic [CNT_W-1:0] frame_bits(fmt_e f);
        case (f)
            FMT_DRV8:   return 5'd8;
            FMT_DRV16C: return 5'd16;
            FMT_REG16:  return 5'd16;
            default:    return 5'd24;
        endcase
    endfunction

    // bits covered by the checksum
    function automatic logic [CNT_W-1:0] body_bits(fmt_e f);
        case (f)
            FMT_DRV8:   return 5'd8;
            FMT_DRV16C: return 5'd11;
            FMT_REG16:  return 5'd16;
            default:    return 5'd19;
        endcase
    endfunction

    function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/outstage_spi_sync.sv
module outstage_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdi_s,
    output logic cs_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise
);
    // bit 2 = sclk, bit 1 = cs_n, bit 0 = sdi
    localparam logic [2:0] PIPE_RST = 3'b010;

    logic [2:0] pipe [STAGES];
    logic [1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= PIPE_RST;
                    else        pipe[0] <= {sclk, cs_n, sdi};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= PIPE_RST;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b01;
        else        prev_q <= pipe[STAGES-1][2:1];
    end

    assign sdi_s     = pipe[STAGES-1][0];
    assign cs_s      = pipe[STAGES-1][1];
    assign sclk_rise =  pipe[STAGES-1][2] & ~prev_q[1];
    assign sclk_fall = ~pipe[STAGES-1][2] &  prev_q[1];
    assign cs_fall   = ~pipe[STAGES-1][1] &  prev_q[0];
    assign cs_rise   =  pipe[STAGES-1][1] & ~prev_q[0];

endmodule

// File: rtl/outstage_spi_regs.sv
module outstage_spi_regs #(
    parameter int          ADDR_W     = 7,
    parameter int          DATA_W     = 8,
    parameter logic [6:0]  DRIVE_ADDR = 7'h00,
    parameter logic [6:0]  DIAG_ADDR  = 7'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] diag_snap,
    output logic [DATA_W-1:0] drive_q,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            drive_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(DRIVE_ADDR))
            drive_q <= wr_data;
    end

    always_comb begin
        if (rd_addr == ADDR_W'(DRIVE_ADDR))     rd_data = drive_q;
        else if (rd_addr == ADDR_W'(DIAG_ADDR)) rd_data = diag_snap;
        else                                    rd_data = '0;
    end

    a_r5_drive_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_q) |-> $past(wr_en && wr_addr == ADDR_W'(DRIVE_ADDR)));

endmodule

// File: rtl/outstage_spi_slave.sv
module outstage_spi_slave
    import outstage_spi_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DRIVE_ADDR  = 7'h00,
    parameter logic [6:0] DIAG_ADDR   = 7'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdi,
    input  logic [1:0] mode_sel,
    input  logic [7:0] diag_in,
    input  logic       uv,
    input  logic       mv,
    input  logic       cf,
    output logic       sdo,
    output logic       sdo_oe,
    output logic [7:0] drive,
    output logic       crc_err
);
    localparam int ADDR_W = BYTE_W - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic sdi_s, cs_s, sclk_rise, sclk_fall, cs_fall, cs_rise;

    st_e                 state_q, state_d;
    fmt_e                mode_q;
    logic [CNT_W-1:0]    bit_cnt;
    logic [SHIFT_W-1:0]  rx_sh;
    logic [CRC_W-1:0]    rx_crc, tx_crc;
    logic [BYTE_W-1:0]   hdr_q, diag_q;
    logic [STAT_W-1:0]   stat_q;
    logic                sdo_q, crc_err_q;
    logic                tx_next, rd_sel;
    logic [BYTE_W-1:0]   rd_data;
    logic                wr_en, frame_ok, len_ok, sum_ok;
    logic [ADDR_W-1:0]   wr_addr;
    logic [BYTE_W-1:0]   wr_data;

    outstage_spi_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdi_s(sdi_s), .cs_s(cs_s), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    outstage_spi_regs #(
        .ADDR_W(ADDR_W), .DATA_W(BYTE_W),
        .DRIVE_ADDR(DRIVE_ADDR), .DIAG_ADDR(DIAG_ADDR)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(hdr_q[ADDR_W-1:0]), .diag_snap(diag_q),
        .drive_q(drive), .rd_data(rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // return bit for position bit_cnt
    always_comb begin
        rd_sel  = ~hdr_q[BYTE_W-1];
        tx_next = 1'b0;
        if (bit_cnt < 5'd8) begin
            tx_next = diag_q[3'(5'd7 - bit_cnt)];
        end else begin
            case (mode_q)
                FMT_DRV16C: begin
                    if (bit_cnt < 5'd11)      tx_next = stat_q[2'(5'd10 - bit_cnt)];
                    else if (bit_cnt < 5'd16) tx_next = tx_crc[3'(5'd15 - bit_cnt)];
                end
                FMT_REG16: begin
                    if (bit_cnt < 5'd16) tx_next = rd_sel & rd_data[3'(5'd15 - bit_cnt)];
                end
                FMT_REG24C: begin
                    if (bit_cnt < 5'd16)      tx_next = rd_sel & rd_data[3'(5'd15 - bit_cnt)];
                    else if (bit_cnt < 5'd19) tx_next = stat_q[2'(5'd18 - bit_cnt)];
                    else if (bit_cnt < 5'd24) tx_next = tx_crc[3'(5'd23 - bit_cnt)];
                end
                default: tx_next = 1'b0;
            endcase
        end
    end

    // frame checks and write decode in ST_COMMIT
    always_comb begin
        len_ok   = (bit_cnt == frame_bits(mode_q));
        sum_ok   = ~mode_q[0] | (rx_crc == rx_sh[CRC_W-1:0]);
        frame_ok = len_ok & sum_ok;
        wr_addr  = ADDR_W'(DRIVE_ADDR);
        wr_data  = '0;
        wr_en    = 1'b0;
        case (mode_q)
            FMT_DRV8: begin
                wr_data = rx_sh[7:0];
                wr_en   = 1'b1;
            end
            FMT_DRV16C: begin
                wr_data = rx_sh[15:8];
                wr_en   = 1'b1;
            end
            FMT_REG16: begin
                wr_addr = rx_sh[14:8];
                wr_data = rx_sh[7:0];
                wr_en   = rx_sh[15];
            end
            default: begin
                wr_addr = rx_sh[22:16];
                wr_data = rx_sh[15:8];
                wr_en   = rx_sh[23];
            end
        endcase
        wr_en = wr_en & frame_ok & (state_q == ST_COMMIT);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= FMT_DRV8;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_crc    <= CRC_SEED;
            tx_crc    <= CRC_SEED;
            hdr_q     <= '0;
            diag_q    <= '0;
            stat_q    <= '0;
            sdo_q     <= 1'b0;
            crc_err_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_s) mode_q <= fmt_e'(mode_sel);
                    if (cs_fall) begin
                        bit_cnt <= '0;
                        rx_crc  <= CRC_SEED;
                        hdr_q   <= '0;
                        diag_q  <= diag_in;
                        stat_q  <= {uv, mv, cf};
                        sdo_q   <= diag_in[BYTE_W-1];
                        tx_crc  <= crc_step(CRC_SEED, diag_in[BYTE_W-1]);
                    end
                end
                ST_SHIFT: begin
                    if (sclk_rise) begin
                        rx_sh <= {rx_sh[SHIFT_W-2:0], sdi_s};
                        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt < body_bits(mode_q)) rx_crc <= crc_step(rx_crc, sdi_s);
                        if (bit_cnt == 5'd7) hdr_q <= {rx_sh[6:0], sdi_s};
                    end
                    if (sclk_fall) begin
                        sdo_q <= tx_next;
                        if (bit_cnt < body_bits(mode_q)) tx_crc <= crc_step(tx_crc, tx_next);
                    end
                end
                ST_COMMIT: crc_err_q <= ~frame_ok;
                default: ;
            endcase
        end
    end

    // outputs
    assign sdo_oe  = ~cs_n;
    assign sdo     = sdo_q;
    assign crc_err = crc_err_q;

    a_r2_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_q) |-> ($past(sclk_fall) || $past(cs_fall)));

    a_r2_count_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_cnt) |-> ($past(sclk_rise) || $past(cs_fall)));

    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> $stable(mode_q));

    a_r8_drive_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive) |-> $past(state_q == ST_COMMIT));

    a_r9_err_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(crc_err_q) |-> $past(state_q == ST_COMMIT));

endmodule

// File: tb/outstage_spi_slave_tb_top.sv
module outstage_spi_slave_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [7:0] diag_in = 8'h00;
    logic       uv = 1'b0, mv = 1'b0, cf = 1'b0;
    logic       sdo, sdo_oe, crc_err;
    logic [7:0] drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    outstage_spi_slave dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .mode_sel(mode_sel), .diag_in(diag_in), .uv(uv), .mv(mv), .cf(cf),
        .sdo(sdo), .sdo_oe(sdo_oe), .drive(drive), .crc_err(crc_err)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] diag;
        logic [2:0] stat;
        logic [1:0] kind;   // 0 clean, 1 bad checksum, 2 short, 3 long
        logic [7:0] rdata;
        logic [7:0] exp_drv;
        logic       exp_err;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'hA5, 8'h00, 8'h3C, 3'd0, 2'd0, 8'h00, 8'hA5, 1'b0},
        '{2'd0, 8'h5A, 8'h00, 8'hC3, 3'd7, 2'd0, 8'h00, 8'h5A, 1'b0},
        '{2'd1, 8'h0F, 8'h00, 8'h81, 3'd5, 2'd0, 8'h00, 8'h0F, 1'b0},
        '{2'd1, 8'hF0, 8'h00, 8'h18, 3'd2, 2'd1, 8'h00, 8'h0F, 1'b1},
        '{2'd1, 8'h33, 8'h00, 8'hE1, 3'd3, 2'd0, 8'h00, 8'h33, 1'b0},
        '{2'd2, 8'h80, 8'h96, 8'h42, 3'd0, 2'd0, 8'h00, 8'h96, 1'b0},
        '{2'd2, 8'h00, 8'hFF, 8'h24, 3'd0, 2'd0, 8'h96, 8'h96, 1'b0},
        '{2'd2, 8'h01, 8'h00, 8'h7E, 3'd0, 2'd0, 8'h7E, 8'h96, 1'b0},
        '{2'd2, 8'h05, 8'h00, 8'h11, 3'd0, 2'd0, 8'h00, 8'h96, 1'b0},
        '{2'd3, 8'h80, 8'hC8, 8'h99, 3'd6, 2'd0, 8'h00, 8'hC8, 1'b0},
        '{2'd3, 8'h00, 8'h00, 8'h5C, 3'd1, 2'd0, 8'hC8, 8'hC8, 1'b0},
        '{2'd3, 8'h80, 8'h11, 8'h0F, 3'd4, 2'd1, 8'h00, 8'hC8, 1'b1},
        '{2'd3, 8'h85, 8'h22, 8'hF0, 3'd0, 2'd0, 8'h00, 8'hC8, 1'b0},
        '{2'd0, 8'h77, 8'h00, 8'h01, 3'd0, 2'd2, 8'h00, 8'hC8, 1'b1},
        '{2'd0, 8'hE7, 8'h00, 8'h02, 3'd0, 2'd0, 8'h00, 8'hE7, 1'b0},
        '{2'd2, 8'h80, 8'h00, 8'h03, 3'd0, 2'd3, 8'h00, 8'hE7, 1'b1},
        '{2'd1, 8'h6B, 8'h00, 8'h55, 3'd7, 2'd0, 8'h00, 8'h6B, 1'b0}
    };

    // checksum from R7: generator x^5+x^2+1, seed 11111, MSB first
    function automatic logic [4:0] ref_crc(logic [23:0] v, int k);
        logic [4:0] c = 5'h1f;
        for (int i = 0; i < k; i++) begin
            logic top = c[4] ^ v[23-i];
            c = c << 1;
            if (top) c = c ^ 5'b00101;
        end
        return c;
    endfunction

    function automatic int flen(logic [1:0] m);
        return (m == 2'd0) ? 8 : (m == 2'd3) ? 24 : 16;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [1:0] m, input logic [23:0] f, input int n,
                        output logic [23:0] got);
        got = '0;
        mode_sel = m;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(8);
        check("R1 oe during frame", {23'd0, sdo_oe}, 24'd1);
        for (int i = 0; i < n; i++) begin
            sdi = f[23-i];
            wait_clk(8);
            got[23-i] = sdo;
            sclk = 1'b1;
            wait_clk(8);
            sclk = 1'b0;
        end
        wait_clk(8);
        cs_n = 1'b1;
        @(negedge clk);
        check("R1 oe after frame", {23'd0, sdo_oe}, 24'd0);
        wait_clk(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        vec_t t;
        logic [23:0] sdi_f, exp_sdo, got;
        logic rd;
        int n;
        string tag;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check("R11 drive after reset", {16'd0, drive}, 24'h0);
        check("R11 crc_err after reset", {23'd0, crc_err}, 24'h0);
        check("R1 oe idle after reset", {23'd0, sdo_oe}, 24'h0);

        for (int v = 0; v < NV; v++) begin
            t  = VECS[v];
            rd = ~t.b0[7];
            case (t.mode)
                2'd0: begin
                    tag = "R3 R2 mode0";
                    sdi_f = {t.b0, 16'h0};
                    exp_sdo = {t.diag, 16'h0};
                end
                2'd1: begin
                    tag = "R4 R7 mode1";
                    sdi_f = {t.b0, 16'h0};
                    sdi_f[12:8] = ref_crc(sdi_f, 11);
                    if (t.kind == 2'd1) sdi_f[8] = ~sdi_f[8];
                    exp_sdo = {t.diag, t.stat, 13'h0};
                    exp_sdo[12:8] = ref_crc(exp_sdo, 11);
                end
                2'd2: begin
                    tag = "R5 mode2";
                    sdi_f = {t.b0, t.b1, 8'h0};
                    exp_sdo = {t.diag, rd ? t.rdata : 8'h00, 8'h0};
                end
                default: begin
                    tag = "R6 R7 mode3";
                    sdi_f = {t.b0, rd ? 8'h00 : t.b1, 8'h0};
                    sdi_f[4:0] = ref_crc(sdi_f, 19);
                    if (t.kind == 2'd1) sdi_f[0] = ~sdi_f[0];
                    exp_sdo = {t.diag, rd ? t.rdata : 8'h00, t.stat, 5'h0};
                    exp_sdo[4:0] = ref_crc(exp_sdo, 19);
                end
            endcase
            n = flen(t.mode);
            if (t.kind == 2'd2) n = n - 1;
            if (t.kind == 2'd3) n = n + 1;
            diag_in = t.diag;
            {uv, mv, cf} = t.stat;
            xfer(t.mode, sdi_f, n, got);
            if (t.kind < 2'd2)
                check($sformatf("%s sdo vec %0d", tag, v), got, exp_sdo);
            case (t.kind)
                2'd1:    tag = "R9 bad checksum";
                2'd2:    tag = "R8 short frame";
                2'd3:    tag = "R8 long frame";
                default: tag = (v == 12) ? "R5 write other address"
                                         : "R9 clean frame";
            endcase
            check($sformatf("%s drive vec %0d", tag, v), {16'd0, drive}, {16'd0, t.exp_drv});
            check($sformatf("%s crc_err vec %0d", tag, v), {23'd0, crc_err}, {23'd0, t.exp_err});
        end

        // R10: strap change inside a mode-0 frame must not alter its decoding
        mode_sel = 2'd0;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) mode_sel = 2'd3;
            sdi = 8'h4D >> (7 - i);
            wait_clk(8);
            sclk = 1'b1;
            wait_clk(8);
            sclk = 1'b0;
        end
        wait_clk(8);
        cs_n = 1'b1;
        wait_clk(12);
        check("R10 drive after mid-frame strap change", {16'd0, drive}, 24'h00004D);
        check("R10 crc_err after mid-frame strap change", {23'd0, crc_err}, 24'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule